// File: doc/BRIEF.md
# Page Row Streamer with 8-bit to 16-bit Colour Expansion

This block moves one band of pixel rows out of a small page buffer and onto the 8-bit parallel bus of a display controller. The buffer holds one byte per pixel in 3-3-2 red/green/blue format. The panel expects 16-bit 5-6-5 pixels, so each pixel is widened on the fly and sent as two bytes.

A one-cycle `page_start` pulse starts a page. With it come the first row number, the number of rows and the pixel count per row. For every row the block first moves the controller's write cursor. It puts the column register at zero and the row register at the current row number, then opens the controller's memory-write register. It then streams the pixels of that row. Row numbers count up by one per row. The page buffer is read through a port with one cycle of read latency. Rows lie back to back in that buffer, so the read address simply steps through the page. The next pixel is fetched while the second byte of the current one is on the bus, so one byte goes out on every clock from the first header byte of the page to its last pixel byte.

Chip select stays asserted across the whole page. It drops one cycle after the final byte, in the same cycle as a single-cycle `page_done` pulse.

Top module: `rgb_row_streamer`

## Requirements
- R1: During and directly after reset, `bus_cs`, `bus_wr`, `page_done` and `rd_en` are all low.
- R2: Every row opens with ten bytes. With `bus_rs`=0 (command) it sends 0x00,0x20, and with `bus_rs`=1 (data) it sends 0x00,0x00. Then command 0x00,0x21, then data with the row number high byte first, then command 0x00,0x22.
- R3: A buffer byte p carries red in bits 7:5, green in bits 4:2 and blue in bits 1:0. It leaves as a high byte {p[7:5], p[7:6], p[4:2]} followed by a low byte {p[4:2], p[1:0], p[1:0], 1'b0}.
- R4: After its header, each row sends exactly `line_width` pixels with `bus_rs`=1, each pixel as its high byte and then its low byte.
- R5: The first row uses `page_y0`, and each further row uses the previous row number plus one, modulo 2^16. The page holds exactly `page_rows` rows. `page_rows` and `line_width` must be at least 1.
- R6: The first buffer read of a page is at address 0, and each later read is at the previous address plus one. Read data is taken in the cycle after `rd_en`.
- R7: `bus_wr` is high in every cycle from the first byte of a page to its last byte, with no gaps, including between rows.
- R8: `bus_wr` is high only while `bus_cs` is high. `bus_cs` falls in the cycle after the last byte of the page, together with a one-cycle `page_done`.
- R9: A `page_start` that arrives while a page is in progress is ignored. It has no effect on the byte stream, and it does not start another page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| page_start | input | 1 | One-cycle request to stream a page |
| page_y0 | input | 16 | Row number of the first row of the page |
| page_rows | input | ROW_W | Rows in the page, 1 to MAX_ROWS |
| line_width | input | COL_W | Pixels per row, 1 to MAX_WIDTH |
| rd_en | output | 1 | Page buffer read request |
| rd_addr | output | ADDR_W | Page buffer read address |
| rd_data | input | 8 | Buffer pixel, valid the cycle after rd_en |
| bus_d | output | 8 | Parallel bus byte |
| bus_rs | output | 1 | 0 = command byte, 1 = data byte |
| bus_wr | output | 1 | Write strobe, one byte per high cycle |
| bus_cs | output | 1 | Controller select, high for the whole page |
| page_done | output | 1 | One-cycle pulse after the final byte |

## Verification
The bench builds the block with MAX_WIDTH=12 and MAX_ROWS=4. Full-width, full-height pages therefore take only about 140 cycles, so single-pixel rows, single-row pages and complete pages all fit into one short run. At that size the row counter can also be started at 0x00FF and at 0xFFFE, which reaches the carry into the high cursor byte and the wrap from 0xFFFF to 0x0000. A page started during another page checks that requests arriving mid-page are dropped.

// File: rtl/px_pkg.sv
package px_pkg;
  localparam logic [7:0] IDX_COL_ADDR = 8'h20;
  localparam logic [7:0] IDX_ROW_ADDR = 8'h21;
  localparam logic [7:0] IDX_MEM_WR   = 8'h22;
  localparam logic [3:0] HDR_LAST     = 4'd9;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PIX, ST_FIN} seq_state_t;
  typedef enum logic [1:0] {K_NONE, K_HDR, K_PIX_HI, K_PIX_LO} emit_kind_t;

  typedef struct packed {
    logic       rs;
    logic [7:0] d;
  } bus_byte_t;
endpackage

// File: rtl/px_hdr_gen.sv
module px_hdr_gen
  import px_pkg::*;
(
  input  logic [3:0]  step,
  input  logic [15:0] row_num,
  output bus_byte_t   hb
);
  always_comb begin
    case (step)
      4'd0:    hb = '{rs: 1'b0, d: 8'h00};
      4'd1:    hb = '{rs: 1'b0, d: IDX_COL_ADDR};
      4'd2:    hb = '{rs: 1'b1, d: 8'h00};
      4'd3:    hb = '{rs: 1'b1, d: 8'h00};
      4'd4:    hb = '{rs: 1'b0, d: 8'h00};
      4'd5:    hb = '{rs: 1'b0, d: IDX_ROW_ADDR};
      4'd6:    hb = '{rs: 1'b1, d: row_num[15:8]};
      4'd7:    hb = '{rs: 1'b1, d: row_num[7:0]};
      4'd8:    hb = '{rs: 1'b0, d: 8'h00};
      default: hb = '{rs: 1'b0, d: IDX_MEM_WR};
    endcase
  end
endmodule

// File: rtl/px_expand.sv
module px_expand (
  input  logic [7:0] pix,
  output logic [7:0] hi,
  output logic [7:0] lo
);
  logic [2:0] red, grn;
  logic [1:0] blu;

  always_comb begin
    red = pix[7:5];
    grn = pix[4:2];
    blu = pix[1:0];
    hi  = {red, red[2:1], grn};
    lo  = {grn, blu, blu, 1'b0};
  end
endmodule

// File: rtl/px_row_seq.sv
module px_row_seq
  import px_pkg::*;
#(
  parameter int MAX_WIDTH = 240,
  parameter int MAX_ROWS  = 4,
  localparam int COL_W  = $clog2(MAX_WIDTH + 1),
  localparam int ROW_W  = $clog2(MAX_ROWS + 1),
  localparam int ADDR_W = (MAX_WIDTH * MAX_ROWS > 1) ? $clog2(MAX_WIDTH * MAX_ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [15:0]       y0,
  input  logic [ROW_W-1:0]  rows_in,
  input  logic [COL_W-1:0]  width_in,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output emit_kind_t        kind,
  output logic [3:0]        hdr_step,
  output logic [15:0]       y_cur,
  output logic              fin
);
  seq_state_t        state;
  logic [COL_W-1:0]  col, width_q;
  logic [ROW_W-1:0]  row, rows_q;
  logic [ADDR_W-1:0] addr;
  logic              phase;
  logic              last_col, last_row;

  assign last_col = (col == width_q - COL_W'(1));
  assign last_row = (row == rows_q - ROW_W'(1));

  always_comb begin
    rd_en = ((state == ST_HDR) && (hdr_step == HDR_LAST)) ||
            ((state == ST_PIX) && phase && !last_col);
    rd_addr = addr;
    fin = (state == ST_FIN);
    case (state)
      ST_HDR:  kind = K_HDR;
      ST_PIX:  kind = phase ? K_PIX_LO : K_PIX_HI;
      default: kind = K_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      hdr_step <= '0;
      y_cur    <= '0;
      col      <= '0;
      row      <= '0;
      width_q  <= '0;
      rows_q   <= '0;
      addr     <= '0;
      phase    <= 1'b0;
    end else begin
      if (rd_en) addr <= addr + ADDR_W'(1);
      case (state)
        ST_IDLE: begin
          if (start) begin
            y_cur    <= y0;
            rows_q   <= rows_in;
            width_q  <= width_in;
            row      <= '0;
            hdr_step <= '0;
            addr     <= '0;
            state    <= ST_HDR;
          end
        end
        ST_HDR: begin
          if (hdr_step == HDR_LAST) begin
            state <= ST_PIX;
            phase <= 1'b0;
            col   <= '0;
          end else begin
            hdr_step <= hdr_step + 4'd1;
          end
        end
        ST_PIX: begin
          phase <= ~phase;
          if (phase) begin
            if (!last_col) begin
              col <= col + COL_W'(1);
            end else if (last_row) begin
              state <= ST_FIN;
            end else begin
              state    <= ST_HDR;
              hdr_step <= '0;
              row      <= row + ROW_W'(1);
              y_cur    <= y_cur + 16'd1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9
  busy_ignores_start_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PIX && start) |=> $stable(rows_q) && $stable(width_q));

  // R5
  row_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PIX && phase && last_col && !last_row) |=> (y_cur == $past(y_cur) + 16'd1));
endmodule

// File: rtl/rgb_row_streamer.sv
module rgb_row_streamer
  import px_pkg::*;
#(
  parameter int MAX_WIDTH = 240,
  parameter int MAX_ROWS  = 4,
  localparam int COL_W  = $clog2(MAX_WIDTH + 1),
  localparam int ROW_W  = $clog2(MAX_ROWS + 1),
  localparam int ADDR_W = (MAX_WIDTH * MAX_ROWS > 1) ? $clog2(MAX_WIDTH * MAX_ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              page_start,
  input  logic [15:0]       page_y0,
  input  logic [ROW_W-1:0]  page_rows,
  input  logic [COL_W-1:0]  line_width,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic [7:0]        bus_d,
  output logic              bus_rs,
  output logic              bus_wr,
  output logic              bus_cs,
  output logic              page_done
);
  emit_kind_t  kind;
  logic [3:0]  hdr_step;
  logic [15:0] y_cur;
  logic        fin;
  bus_byte_t   hb;
  logic [7:0]  pix_q, exp_src, exp_hi, exp_lo;

  px_row_seq #(.MAX_WIDTH(MAX_WIDTH), .MAX_ROWS(MAX_ROWS)) u_seq (
    .clk(clk), .rst(rst), .start(page_start), .y0(page_y0),
    .rows_in(page_rows), .width_in(line_width),
    .rd_en(rd_en), .rd_addr(rd_addr), .kind(kind),
    .hdr_step(hdr_step), .y_cur(y_cur), .fin(fin)
  );

  px_hdr_gen u_hdr (.step(hdr_step), .row_num(y_cur), .hb(hb));

  assign exp_src = (kind == K_PIX_LO) ? pix_q : rd_data;

  px_expand u_exp (.pix(exp_src), .hi(exp_hi), .lo(exp_lo));

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_d     <= '0;
      bus_rs    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_cs    <= 1'b0;
      page_done <= 1'b0;
      pix_q     <= '0;
    end else begin
      bus_wr    <= (kind != K_NONE);
      bus_cs    <= (kind != K_NONE);
      page_done <= fin;
      if (kind == K_PIX_HI) pix_q <= rd_data;
      case (kind)
        K_HDR:    begin bus_rs <= hb.rs; bus_d <= hb.d;   end
        K_PIX_HI: begin bus_rs <= 1'b1;  bus_d <= exp_hi; end
        K_PIX_LO: begin bus_rs <= 1'b1;  bus_d <= exp_lo; end
        default:  begin bus_rs <= 1'b0;  bus_d <= '0;     end
      endcase
    end
  end

  logic              rd_seen;
  logic [ADDR_W-1:0] rd_last;
  always_ff @(posedge clk) begin
    if (rst || page_done) begin
      rd_seen <= 1'b0;
      rd_last <= '0;
    end else if (rd_en) begin
      rd_seen <= 1'b1;
      rd_last <= rd_addr;
    end
  end

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_seen) |-> (rd_addr == rd_last + ADDR_W'(1)));

  // R6
  addr_first_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_seen) |-> (rd_addr == '0));

  // R7
  no_stall_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> ##1 (bus_wr && bus_rs));

  // R8
  wr_in_cs_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr |-> bus_cs);

  // R8
  cs_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_cs) |-> page_done);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    page_done |=> !page_done);
endmodule

// File: tb/sim_rgb_row_streamer.sv
module sim_rgb_row_streamer;
  localparam int MW = 12;
  localparam int MR = 4;
  localparam int COL_W  = $clog2(MW + 1);
  localparam int ROW_W  = $clog2(MR + 1);
  localparam int ADDR_W = $clog2(MW * MR);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic page_start = 1'b0;
  logic [15:0] page_y0 = '0;
  logic [ROW_W-1:0] page_rows = '0;
  logic [COL_W-1:0] line_width = '0;
  logic rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0] rd_data = '0;
  logic [7:0] bus_d;
  logic bus_rs, bus_wr, bus_cs, page_done;

  always #10 clk = ~clk;

  rgb_row_streamer #(.MAX_WIDTH(MW), .MAX_ROWS(MR)) u0 (
    .clk(clk), .rst(rst), .page_start(page_start), .page_y0(page_y0),
    .page_rows(page_rows), .line_width(line_width), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .bus_d(bus_d), .bus_rs(bus_rs),
    .bus_wr(bus_wr), .bus_cs(bus_cs), .page_done(page_done)
  );

  logic [7:0] mem [0:MW*MR-1];
  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int cycles = 0;
  bit finished = 0;
  logic [8:0] expq [$];
  string tagq [$];
  bit in_page = 0;
  bit prev_wr = 0;
  int exp_addr = 0;

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [7:0] px_hi(logic [7:0] p);
    return {p[7:5], p[7:6], p[4:2]};
  endfunction
  function automatic logic [7:0] px_lo(logic [7:0] p);
    return {p[4:2], p[1:0], p[1:0], 1'b0};
  endfunction

  task automatic push(logic rs, logic [7:0] d, string tag);
    expq.push_back({rs, d});
    tagq.push_back(tag);
  endtask

  // Monitor: compares the bus against the scoreboard away from the clock edge.
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      if (rd_en) begin
        checks++;
        if (int'(rd_addr) != exp_addr) begin
          errors++;
          $display("FAIL R6 rd_addr actual %0d expected %0d", rd_addr, exp_addr);
        end
        exp_addr++;
      end
      if (bus_wr) begin
        checks++;
        if (!bus_cs) begin
          errors++;
          $display("FAIL R8 bus_cs actual 0 expected 1 during write");
        end
        if (expq.size() == 0) begin
          errors++;
          $display("FAIL R9 unexpected byte actual %02h expected none", bus_d);
        end else begin
          logic [8:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          if ({bus_rs, bus_d} !== e) begin
            errors++;
            $display("FAIL %s byte actual rs=%0d d=%02h expected rs=%0d d=%02h",
                     t, bus_rs, bus_d, e[8], e[7:0]);
          end
        end
        in_page = 1;
      end else if (in_page && expq.size() != 0) begin
        checks++;
        errors++;
        $display("FAIL R7 bus_wr actual 0 expected 1 with %0d bytes pending", expq.size());
      end
      if (page_done) begin
        checks++;
        if (!prev_wr || bus_cs || expq.size() != 0) begin
          errors++;
          $display("FAIL R8 done: prev_wr actual %0d expected 1, cs actual %0d expected 0, left actual %0d expected 0",
                   prev_wr, bus_cs, expq.size());
        end
        done_cnt++;
        in_page = 0;
      end
      prev_wr = bus_wr;
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual %0d cycles expected fewer", cycles);
      summary();
    end
  end

  task automatic run_page(logic [15:0] y0, int rows, int width, bit poke);
    int target;
    int base;
    logic [15:0] y;
    target = done_cnt + 1;
    base = 0;
    for (int r = 0; r < rows; r++) begin
      y = y0 + 16'(r);
      push(1'b0, 8'h00, "R2"); push(1'b0, 8'h20, "R2");
      push(1'b1, 8'h00, "R2"); push(1'b1, 8'h00, "R2");
      push(1'b0, 8'h00, "R2"); push(1'b0, 8'h21, "R2");
      push(1'b1, y[15:8], "R5"); push(1'b1, y[7:0], "R5");
      push(1'b0, 8'h00, "R2"); push(1'b0, 8'h22, "R2");
      for (int c = 0; c < width; c++) begin
        push(1'b1, px_hi(mem[base]), "R3");
        push(1'b1, px_lo(mem[base]), "R4");
        base++;
      end
    end
    exp_addr = 0;
    page_y0 = y0;
    page_rows = ROW_W'(rows);
    line_width = COL_W'(width);
    page_start = 1'b1;
    @(negedge clk);
    page_start = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      page_y0 = 16'h1234; page_rows = ROW_W'(1); line_width = COL_W'(1);
      page_start = 1'b1;
      @(negedge clk);
      page_start = 1'b0;
    end
    while (done_cnt < target) @(negedge clk);
    repeat (4) @(negedge clk);
    checks++;
    if (bus_cs || done_cnt != target) begin
      errors++;
      $display("FAIL R9 after page: cs actual %0d expected 0, pages actual %0d expected %0d",
               bus_cs, done_cnt, target);
    end
  endtask

  initial begin
    for (int i = 0; i < MW*MR; i++) mem[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    checks++;
    if (bus_cs || bus_wr || page_done || rd_en) begin
      errors++;
      $display("FAIL R1 in reset: cs %0d wr %0d done %0d rd %0d expected all 0",
               bus_cs, bus_wr, page_done, rd_en);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (bus_cs || bus_wr || page_done || rd_en) begin
      errors++;
      $display("FAIL R1 after reset: cs %0d wr %0d done %0d rd %0d expected all 0",
               bus_cs, bus_wr, page_done, rd_en);
    end
    // single pixel, single row, all-ones colour (R3, R4)
    mem[0] = 8'hFF;
    run_page(16'h0000, 1, 1, 0);
    // full page with row high byte nonzero (R5, R6, R7)
    for (int i = 0; i < MW*MR; i++) mem[i] = 8'(i * 37 + 5);
    run_page(16'h01FF, MR, MW, 0);
    // row number wraps 0xFFFF -> 0x0000 (R5)
    for (int i = 0; i < MW*MR; i++) mem[i] = 8'(i * 73) ^ 8'hA5;
    run_page(16'hFFFE, 3, 5, 0);
    // single-pixel rows across the 0x00FF carry (R4, R5, R6)
    mem[0] = 8'h00; mem[1] = 8'hE0; mem[2] = 8'h1C;
    run_page(16'h00FF, 3, 1, 0);
    // request mid-page is dropped (R9)
    for (int i = 0; i < MW*MR; i++) mem[i] = 8'(255 - i * 11);
    run_page(16'h0040, MR, MW, 1);
    checks++;
    if (done_cnt != 5) begin
      errors++;
      $display("FAIL R8 page_done pulses actual %0d expected 5", done_cnt);
    end
    summary();
  end
endmodule